// File: doc/BRIEF.md
# TLB Fence Request Dispatcher

This block sits behind the retire stage of a hart. For every address-translation fence that retires, it receives the address operand, the address-space operand and two flags that say whether each operand came from the zero register. It turns that request into an invalidation command for the hart's own TLB. When the request asks for it, the block also sends a packet to the system interconnect so that other translation caches, such as an IOMMU, can drop the same entries.

The address-space operand packs three fields: a broadcast/local selector, the physical page number of the root page table, and the ASID. The root-table PPN is a tag for the address space that stays fixed for the life of that space, so remote caches can use it even though they do not share the hart's ASID numbering. A parameter selects a 32-bit or a 64-bit operand layout.

A broadcast packet waits in a single holding slot until the interconnect takes it. New fence requests are held off until the slot is free. Each handshake on the interconnect produces a one-cycle strobe, which an outstanding-operation tracker elsewhere can count.

Top module: `tlb_fence_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1, and `bc_valid`, `bc_issued` and `loc_inv_valid` are all 0.
- R2: With `XLEN`=64, the address-space operand decodes as follows: bit 63 is the selector, bits 59:16 are the 44-bit root PPN, and bits 15:0 are the 16-bit ASID. Bits 62:60 have no effect on any output.
- R3: With `XLEN`=32, the address-space operand decodes as follows: bit 31 is the selector, bits 30:9 are the 22-bit root PPN, and bits 8:0 are the 9-bit ASID.
- R4: `loc_inv_scope` encodes the fence scope as follows:
  - bit 1 = 1 means the fence is limited to one address.
  - bit 0 = 1 means the fence is limited to one address space, with global mappings excluded.
  - The four codes are: 00 = all spaces and all addresses (both operands zero-register), 01 = all addresses of one space, 10 = one leaf address in all spaces, 11 = one leaf address in one space.
  - `loc_inv_addr` is 0 when the address operand is the zero register.
- R5: A selector value of 1 requests broadcast and 0 requests local only. When the address-space operand is the zero register, the request is treated as local, and the ASID and PPN outputs are 0 whatever the operand value.
- R6: `loc_inv_valid` is 1 in exactly the cycles in which a request is accepted (`req_valid` and `req_ready` both 1). Its fields describe that request in the same cycle.
- R7: A request accepted with broadcast selected raises `bc_valid` in the next cycle. The packet carries the decoded address, ASID, stage-1 PPN, the request's VMID and stage-2 PPN, and the scope. The packet stays unchanged until `bc_ready` is seen. Local requests produce no packet.
- R8: `req_ready` is 0 in every cycle in which `bc_valid` is 1.
- R9: `bc_issued` is 1 for exactly one cycle per packet, in the cycle of the `bc_valid`/`bc_ready` handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Retired fence request present |
| req_ready | output | 1 | Dispatcher can accept a request |
| req_addr | input | XLEN | Address operand |
| req_space | input | XLEN | Address-space operand (selector, root PPN, ASID) |
| req_addr_zero | input | 1 | Address operand was the zero register |
| req_space_zero | input | 1 | Address-space operand was the zero register |
| req_vmid | input | VMID_W | Current VMID, carried in broadcast packets |
| req_s2_ppn | input | PPN_W | Current stage-2 root PPN, carried in broadcast packets |
| loc_inv_valid | output | 1 | Local TLB invalidation command |
| loc_inv_scope | output | 2 | Scope code (see R4) |
| loc_inv_addr | output | XLEN | Invalidation address |
| loc_inv_asid | output | ASID_W | Invalidation ASID |
| loc_inv_ppn | output | PPN_W | Invalidation root PPN |
| bc_valid | output | 1 | Broadcast packet valid |
| bc_ready | input | 1 | Interconnect accepts the packet |
| bc_scope | output | 2 | Packet scope code |
| bc_addr | output | XLEN | Packet address |
| bc_asid | output | ASID_W | Packet ASID |
| bc_s1_ppn | output | PPN_W | Packet stage-1 root PPN |
| bc_vmid | output | VMID_W | Packet VMID |
| bc_s2_ppn | output | PPN_W | Packet stage-2 root PPN |
| bc_issued | output | 1 | One-cycle strobe per completed packet handshake |

## Verification
Two events can fall in the same cycle: a packet handshake that frees the slot, and a new request waiting at the input. The bench holds the interconnect ready low while a broadcast is pending and a second request is already queued. It then raises ready, and also toggles ready at random across a long random run. In the handshake cycle, the reference model expects the issued strobe and a stalled input together. It expects the waiting request, with its same-cycle local pulse, one cycle later. Every cycle, the model compares both a 64-bit and a 32-bit instance against that expectation.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

   typedef enum logic [1:0] {
      SCOPE_ALL        = 2'b00,
      SCOPE_SPACE      = 2'b01,
      SCOPE_LEAF_ANY   = 2'b10,
      SCOPE_LEAF_SPACE = 2'b11
   } fence_scope_e;

   function automatic int ppn_width(input int xlen);
      return (xlen == 32) ? 22 : 44;
   endfunction

   function automatic int asid_width(input int xlen);
      return (xlen == 32) ? 9 : 16;
   endfunction

endpackage

// File: rtl/tfd_rs2_decode.sv
module tfd_rs2_decode #(
   parameter int XLEN = 64,
   localparam int PPN_W  = tfd_pkg::ppn_width(XLEN),
   localparam int ASID_W = tfd_pkg::asid_width(XLEN)
) (
   input  logic [XLEN-1:0]   space_i,
   input  logic              space_zero_i,
   output logic              bcast_o,
   output logic [PPN_W-1:0]  ppn_o,
   output logic [ASID_W-1:0] asid_o
);

   logic              raw_bcast;
   logic [PPN_W-1:0]  raw_ppn;
   logic [ASID_W-1:0] raw_asid;

   generate
      if (XLEN == 32) begin : g_rv32
         assign raw_bcast = space_i[31];
         assign raw_ppn   = space_i[30:9];
         assign raw_asid  = space_i[8:0];
      end else if (XLEN == 64) begin : g_rv64
         logic unused_rsvd;
         assign unused_rsvd = ^space_i[62:60];
         assign raw_bcast = space_i[63];
         assign raw_ppn   = space_i[59:16];
         assign raw_asid  = space_i[15:0];
      end else begin : g_bad_xlen
         $error("tfd_rs2_decode: XLEN must be 32 or 64");
      end
   endgenerate

   // A zero-register operand supplies no fields: local, all-zero tags.
   always_comb begin
      if (space_zero_i) begin
         bcast_o = 1'b0;
         ppn_o   = '0;
         asid_o  = '0;
      end else begin
         bcast_o = raw_bcast;
         ppn_o   = raw_ppn;
         asid_o  = raw_asid;
      end
   end

endmodule

// File: rtl/tfd_scope_sel.sv
module tfd_scope_sel #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]        addr_i,
   input  logic                   addr_zero_i,
   input  logic                   space_zero_i,
   output tfd_pkg::fence_scope_e  scope_o,
   output logic [XLEN-1:0]        addr_o
);

   always_comb begin
      unique case ({addr_zero_i, space_zero_i})
         2'b11:   scope_o = tfd_pkg::SCOPE_ALL;
         2'b10:   scope_o = tfd_pkg::SCOPE_SPACE;
         2'b01:   scope_o = tfd_pkg::SCOPE_LEAF_ANY;
         default: scope_o = tfd_pkg::SCOPE_LEAF_SPACE;
      endcase
      addr_o = addr_zero_i ? '0 : addr_i;
   end

endmodule

// File: rtl/tfd_bcast_slot.sv
module tfd_bcast_slot #(
   parameter int ADDR_W = 64,
   parameter int ASID_W = 16,
   parameter int PPN_W  = 44,
   parameter int VMID_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [1:0]        scope_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ASID_W-1:0] asid_i,
   input  logic [PPN_W-1:0]  s1_ppn_i,
   input  logic [VMID_W-1:0] vmid_i,
   input  logic [PPN_W-1:0]  s2_ppn_i,
   output logic              valid_o,
   input  logic              ready_i,
   output logic [1:0]        scope_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ASID_W-1:0] asid_o,
   output logic [PPN_W-1:0]  s1_ppn_o,
   output logic [VMID_W-1:0] vmid_o,
   output logic [PPN_W-1:0]  s2_ppn_o,
   output logic              issued_o
);

   generate
      if (ADDR_W < 1 || ASID_W < 1 || PPN_W < 1 || VMID_W < 1) begin : g_bad_width
         $error("tfd_bcast_slot: all field widths must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
      end else if (load_i) begin
         valid_o <= 1'b1;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scope_o  <= '0;
         addr_o   <= '0;
         asid_o   <= '0;
         s1_ppn_o <= '0;
         vmid_o   <= '0;
         s2_ppn_o <= '0;
      end else if (load_i) begin
         scope_o  <= scope_i;
         addr_o   <= addr_i;
         asid_o   <= asid_i;
         s1_ppn_o <= s1_ppn_i;
         vmid_o   <= vmid_i;
         s2_ppn_o <= s2_ppn_i;
      end
   end

   assign issued_o = valid_o && ready_i;

endmodule

// File: rtl/tlb_fence_dispatch.sv
module tlb_fence_dispatch #(
   parameter int XLEN   = 64,
   parameter int VMID_W = 14,
   localparam int PPN_W  = tfd_pkg::ppn_width(XLEN),
   localparam int ASID_W = tfd_pkg::asid_width(XLEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [XLEN-1:0]   req_addr,
   input  logic [XLEN-1:0]   req_space,
   input  logic              req_addr_zero,
   input  logic              req_space_zero,
   input  logic [VMID_W-1:0] req_vmid,
   input  logic [PPN_W-1:0]  req_s2_ppn,
   output logic              loc_inv_valid,
   output logic [1:0]        loc_inv_scope,
   output logic [XLEN-1:0]   loc_inv_addr,
   output logic [ASID_W-1:0] loc_inv_asid,
   output logic [PPN_W-1:0]  loc_inv_ppn,
   output logic              bc_valid,
   input  logic              bc_ready,
   output logic [1:0]        bc_scope,
   output logic [XLEN-1:0]   bc_addr,
   output logic [ASID_W-1:0] bc_asid,
   output logic [PPN_W-1:0]  bc_s1_ppn,
   output logic [VMID_W-1:0] bc_vmid,
   output logic [PPN_W-1:0]  bc_s2_ppn,
   output logic              bc_issued
);

   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("tlb_fence_dispatch: XLEN must be 32 or 64");
      end
      if (VMID_W < 1 || VMID_W > 16) begin : g_bad_vmid
         $error("tlb_fence_dispatch: VMID_W must be 1..16");
      end
   endgenerate

   logic                  want_bcast;
   logic [PPN_W-1:0]      dec_ppn;
   logic [ASID_W-1:0]     dec_asid;
   tfd_pkg::fence_scope_e dec_scope;
   logic [XLEN-1:0]       dec_addr;
   logic                  accept;
   logic                  slot_busy;

   tfd_rs2_decode #(.XLEN(XLEN)) u_decode (
      .space_i      (req_space),
      .space_zero_i (req_space_zero),
      .bcast_o      (want_bcast),
      .ppn_o        (dec_ppn),
      .asid_o       (dec_asid)
   );

   tfd_scope_sel #(.XLEN(XLEN)) u_scope (
      .addr_i       (req_addr),
      .addr_zero_i  (req_addr_zero),
      .space_zero_i (req_space_zero),
      .scope_o      (dec_scope),
      .addr_o       (dec_addr)
   );

   // Single holding slot: intake stalls while a packet waits.
   assign req_ready = !slot_busy;
   assign accept    = req_valid && req_ready;

   assign loc_inv_valid = accept;
   assign loc_inv_scope = dec_scope;
   assign loc_inv_addr  = dec_addr;
   assign loc_inv_asid  = dec_asid;
   assign loc_inv_ppn   = dec_ppn;

   tfd_bcast_slot #(
      .ADDR_W (XLEN),
      .ASID_W (ASID_W),
      .PPN_W  (PPN_W),
      .VMID_W (VMID_W)
   ) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept && want_bcast),
      .scope_i  (dec_scope),
      .addr_i   (dec_addr),
      .asid_i   (dec_asid),
      .s1_ppn_i (dec_ppn),
      .vmid_i   (req_vmid),
      .s2_ppn_i (req_s2_ppn),
      .valid_o  (slot_busy),
      .ready_i  (bc_ready),
      .scope_o  (bc_scope),
      .addr_o   (bc_addr),
      .asid_o   (bc_asid),
      .s1_ppn_o (bc_s1_ppn),
      .vmid_o   (bc_vmid),
      .s2_ppn_o (bc_s2_ppn),
      .issued_o (bc_issued)
   );

   assign bc_valid = slot_busy;

endmodule

// File: rtl/tfd_checker.sv
module tfd_checker #(
   parameter int XLEN = 64,
   localparam int PPN_W  = tfd_pkg::ppn_width(XLEN),
   localparam int ASID_W = tfd_pkg::asid_width(XLEN)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_space_zero,
   input logic              loc_inv_valid,
   input logic [ASID_W-1:0] loc_inv_asid,
   input logic [PPN_W-1:0]  loc_inv_ppn,
   input logic              bc_valid,
   input logic              bc_ready,
   input logic [XLEN-1:0]   bc_addr,
   input logic [ASID_W-1:0] bc_asid,
   input logic [PPN_W-1:0]  bc_s1_ppn,
   input logic              bc_issued
);

   AST_STALL_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      bc_valid |-> !req_ready);                                         // R8

   AST_PACKET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !bc_ready) |=> (bc_valid && $stable(bc_addr) &&
                                   $stable(bc_asid) && $stable(bc_s1_ppn))); // R7

   AST_PACKET_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bc_valid) |-> $past(req_valid && req_ready));               // R7

   AST_ISSUE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      bc_issued |=> !bc_issued);                                        // R9

   AST_LOCAL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      loc_inv_valid |-> (req_valid && req_ready));                      // R6

   AST_ZERO_SPACE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_space_zero) |=> !bc_valid);        // R5

   AST_ZERO_SPACE_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_inv_valid && req_space_zero) |-> (loc_inv_asid == '0 && loc_inv_ppn == '0)); // R5

endmodule

bind tlb_fence_dispatch tfd_checker #(.XLEN(XLEN)) u_tfd_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_ready      (req_ready),
   .req_space_zero (req_space_zero),
   .loc_inv_valid  (loc_inv_valid),
   .loc_inv_asid   (loc_inv_asid),
   .loc_inv_ppn    (loc_inv_ppn),
   .bc_valid       (bc_valid),
   .bc_ready       (bc_ready),
   .bc_addr        (bc_addr),
   .bc_asid        (bc_asid),
   .bc_s1_ppn      (bc_s1_ppn),
   .bc_issued      (bc_issued)
);

// File: tb/tlb_fence_dispatch_tb.sv
`timescale 1ns/1ps
module tlb_fence_dispatch_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;

   // shared stimulus
   logic [63:0] s_addr = '0, s_space = '0, s_s2 = '0;
   logic        s_az = 1'b0, s_sz = 1'b0;
   logic [13:0] s_vmid = '0;
   logic        v [2];
   logic        rdy [2];
   int          rmode = 0;

   // 64-bit instance (index 0)
   logic        q_rdy0, li_v0, bc_v0, iss0;
   logic [1:0]  li_sc0, bc_sc0;
   logic [63:0] li_a0, bc_a0;
   logic [15:0] li_as0, bc_as0;
   logic [43:0] li_p0, bc_p0, bc_s20;
   logic [13:0] bc_vm0;

   // 32-bit instance (index 1)
   logic        q_rdy1, li_v1, bc_v1, iss1;
   logic [1:0]  li_sc1, bc_sc1;
   logic [31:0] li_a1, bc_a1;
   logic [8:0]  li_as1, bc_as1;
   logic [21:0] li_p1, bc_p1, bc_s21;
   logic [13:0] bc_vm1;

   tlb_fence_dispatch #(.XLEN(64), .VMID_W(14)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(v[0]), .req_ready(q_rdy0),
      .req_addr(s_addr), .req_space(s_space), .req_addr_zero(s_az),
      .req_space_zero(s_sz), .req_vmid(s_vmid), .req_s2_ppn(s_s2[43:0]),
      .loc_inv_valid(li_v0), .loc_inv_scope(li_sc0), .loc_inv_addr(li_a0),
      .loc_inv_asid(li_as0), .loc_inv_ppn(li_p0), .bc_valid(bc_v0),
      .bc_ready(rdy[0]), .bc_scope(bc_sc0), .bc_addr(bc_a0), .bc_asid(bc_as0),
      .bc_s1_ppn(bc_p0), .bc_vmid(bc_vm0), .bc_s2_ppn(bc_s20), .bc_issued(iss0));

   tlb_fence_dispatch #(.XLEN(32), .VMID_W(14)) u_dut32 (
      .clk(clk), .rst_n(rst_n), .req_valid(v[1]), .req_ready(q_rdy1),
      .req_addr(s_addr[31:0]), .req_space(s_space[31:0]), .req_addr_zero(s_az),
      .req_space_zero(s_sz), .req_vmid(s_vmid), .req_s2_ppn(s_s2[21:0]),
      .loc_inv_valid(li_v1), .loc_inv_scope(li_sc1), .loc_inv_addr(li_a1),
      .loc_inv_asid(li_as1), .loc_inv_ppn(li_p1), .bc_valid(bc_v1),
      .bc_ready(rdy[1]), .bc_scope(bc_sc1), .bc_addr(bc_a1), .bc_asid(bc_as1),
      .bc_s1_ppn(bc_p1), .bc_vmid(bc_vm1), .bc_s2_ppn(bc_s21), .bc_issued(iss1));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // Reference decode from R2/R3/R5
   function automatic void ref_dec(input int lay, input logic [63:0] sp, input bit sz,
                                   output bit bc, output logic [63:0] ppn, output logic [63:0] asid);
      bc = 1'b0; ppn = '0; asid = '0;
      if (!sz) begin
         if (lay == 1) begin
            bc = sp[31]; ppn = {42'd0, sp[30:9]}; asid = {55'd0, sp[8:0]};
         end else begin
            bc = sp[63]; ppn = {20'd0, sp[59:16]}; asid = {48'd0, sp[15:0]};
         end
      end
   endfunction

   // Reference model state: queued broadcast packet per instance
   bit          m_pend [2];
   logic [63:0] m_addr [2], m_asid [2], m_ppn [2], m_vmid [2], m_s2 [2];
   logic [1:0]  m_scope [2];

   always @(negedge clk) begin
      if (rst_n) begin
         for (int L = 0; L < 2; L++) begin
            bit          o_rdy, o_li, o_bv, o_iss, acc, e_bc;
            logic [1:0]  o_lsc, o_bsc, e_sc;
            logic [63:0] o_la, o_las, o_lp, o_ba, o_bas, o_bp, o_bvm, o_bs2;
            logic [63:0] e_ppn, e_asid, e_addr, e_s2;
            if (L == 0) begin
               o_rdy = q_rdy0; o_li = li_v0; o_bv = bc_v0; o_iss = iss0;
               o_lsc = li_sc0; o_bsc = bc_sc0; o_la = li_a0; o_las = 64'(li_as0);
               o_lp = 64'(li_p0); o_ba = bc_a0; o_bas = 64'(bc_as0); o_bp = 64'(bc_p0);
               o_bvm = 64'(bc_vm0); o_bs2 = 64'(bc_s20);
               e_addr = s_addr; e_s2 = {20'd0, s_s2[43:0]};
            end else begin
               o_rdy = q_rdy1; o_li = li_v1; o_bv = bc_v1; o_iss = iss1;
               o_lsc = li_sc1; o_bsc = bc_sc1; o_la = 64'(li_a1); o_las = 64'(li_as1);
               o_lp = 64'(li_p1); o_ba = 64'(bc_a1); o_bas = 64'(bc_as1); o_bp = 64'(bc_p1);
               o_bvm = 64'(bc_vm1); o_bs2 = 64'(bc_s21);
               e_addr = {32'd0, s_addr[31:0]}; e_s2 = {42'd0, s_s2[21:0]};
            end
            if (s_az) e_addr = '0;
            e_sc = {~s_az, ~s_sz};
            ref_dec(L, s_space, s_sz, e_bc, e_ppn, e_asid);

            chk(o_rdy == !m_pend[L], "R8 req_ready vs pending", 64'(o_rdy), 64'(!m_pend[L]));
            acc = v[L] && !m_pend[L];
            chk(o_li == acc, "R6 local pulse on accept", 64'(o_li), 64'(acc));
            if (acc) begin
               chk(o_lsc == e_sc, "R4 scope code", 64'(o_lsc), 64'(e_sc));
               chk(o_la == e_addr, "R4 local addr", o_la, e_addr);
               chk(o_las == e_asid, (L == 0) ? "R2 asid field" : "R3 asid field", o_las, e_asid);
               chk(o_lp == e_ppn, s_sz ? "R5 zero-space ppn" : ((L == 0) ? "R2 ppn field" : "R3 ppn field"), o_lp, e_ppn);
            end
            chk(o_bv == m_pend[L], "R7 bc_valid", 64'(o_bv), 64'(m_pend[L]));
            if (m_pend[L]) begin
               chk(o_ba == m_addr[L], "R7 packet addr", o_ba, m_addr[L]);
               chk(o_bas == m_asid[L], "R7 packet asid", o_bas, m_asid[L]);
               chk(o_bp == m_ppn[L], "R7 packet s1 ppn", o_bp, m_ppn[L]);
               chk(o_bvm == m_vmid[L], "R7 packet vmid", o_bvm, m_vmid[L]);
               chk(o_bs2 == m_s2[L], "R7 packet s2 ppn", o_bs2, m_s2[L]);
               chk(o_bsc == m_scope[L], "R7 packet scope", 64'(o_bsc), 64'(m_scope[L]));
            end
            chk(o_iss == (m_pend[L] && rdy[L]), "R9 issued strobe", 64'(o_iss), 64'(m_pend[L] && rdy[L]));

            // next state
            if (m_pend[L] && rdy[L]) m_pend[L] = 1'b0;
            if (acc && e_bc) begin
               m_pend[L] = 1'b1; m_addr[L] = e_addr; m_asid[L] = e_asid; m_ppn[L] = e_ppn;
               m_vmid[L] = 64'(s_vmid); m_s2[L] = e_s2; m_scope[L] = e_sc;
            end
         end
      end
   end

   // interconnect ready driver
   initial begin
      rdy[0] = 1'b1; rdy[1] = 1'b1;
      forever begin
         @(posedge clk); #1;
         for (int L = 0; L < 2; L++) begin
            case (rmode)
               0: rdy[L] = 1'b1;
               1: rdy[L] = (($urandom % 3) != 0);
               default: rdy[L] = 1'b0;
            endcase
         end
      end
   end

   task automatic send(input logic [63:0] a, input logic [63:0] sp, input bit az, input bit sz);
      bit a0, a1;
      @(posedge clk); #1;
      s_addr = a; s_space = sp; s_az = az; s_sz = sz;
      s_vmid = 14'($urandom); s_s2 = {$urandom, $urandom};
      v[0] = 1'b1; v[1] = 1'b1;
      while (v[0] || v[1]) begin
         @(negedge clk);
         a0 = v[0] && q_rdy0; a1 = v[1] && q_rdy1;
         @(posedge clk); #1;
         if (a0) v[0] = 1'b0;
         if (a1) v[1] = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL R6 watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      v[0] = 1'b0; v[1] = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(q_rdy0 && q_rdy1, "R1 ready after reset", 64'(q_rdy0), 64'd1);
      chk(!bc_v0 && !bc_v1, "R1 bc_valid after reset", 64'(bc_v0), 64'd0);
      chk(!iss0 && !iss1, "R1 issued after reset", 64'(iss0), 64'd0);
      chk(!li_v0 && !li_v1, "R1 local pulse after reset", 64'(li_v0), 64'd0);

      // R4 all four scope codes, local mode
      send(64'h1234_5678_9abc_d000, 64'h0123_4567_89ab_cdef & ~64'h8000_0000_8000_0000, 1, 1);
      send(64'h1234_5678_9abc_d000, 64'h0123_4567_89ab_cdef & ~64'h8000_0000_8000_0000, 1, 0);
      send(64'hdead_beef_0000_1000, 64'h0123_4567_89ab_cdef & ~64'h8000_0000_8000_0000, 0, 1);
      send(64'hdead_beef_0000_1000, 64'h0555_aaaa_1357_2468 & ~64'h8000_0000_8000_0000, 0, 0);
      // R5 zero-register space with selector bits set: must stay local
      send(64'h0000_0000_0000_4000, 64'hffff_ffff_ffff_ffff, 0, 1);
      // R2 reserved bits 62:60 set, selector clear: local
      send(64'h0000_0000_0000_5000, 64'h7000_0abc_def0_0042, 0, 0);
      // R2/R3 broadcast with full fields, ready immediate
      send(64'h0000_0000_7654_3000, 64'hf00f_ffff_ffff_ffff, 0, 0);
      send(64'h0000_0000_7654_3000, 64'h8000_0000_8000_0001, 1, 0);

      // R8/R9 stall: packet held while ready low, second request waits
      rmode = 2;
      send(64'h0000_0000_0aaa_a000, 64'h8abc_0000_8765_4321, 0, 0);
      fork
         send(64'h0000_0000_0bbb_b000, 64'h8111_2222_8333_4444, 0, 0);
         begin repeat (6) @(posedge clk); rmode = 0; end
      join
      repeat (3) @(posedge clk);

      // random traffic with random interconnect backpressure
      rmode = 1;
      for (int i = 0; i < 400; i++) begin
         send({$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 4) == 0, ($urandom % 4) == 0);
      end
      rmode = 0;
      repeat (5) @(posedge clk);
      finish_run();
   end

endmodule